// File: doc/BRIEF.md
# Flash Array Operation Engine

This block is the storage array and self-timed operation engine of a word-wide NOR flash device. A command decoder upstream hands it one decoded operation at a time: word program, full-array erase, main-region erase, or setting the boot-region lock. Each operation comes with an address and a data word. The engine holds busy for a parameterised number of clock cycles and applies the operation to a behavioural array. It then falls back to normal reads by itself.

Every read of the array goes through a registered read port. While an operation runs, that port does not return array contents. It returns a status word that carries a completion-polling bit and a toggling bit in each byte lane.

The lowest `BOOT_WORDS` words form a boot region. Once the lock is set, the boot region refuses programming and survives a full-array erase. The defaults keep the simulated array small (1K words, 128 boot words). A full-size instance uses `ADDR_W = 16` and `BOOT_WORDS = 8192`, which gives a 64K-word array with an 8K-word boot region.

The control is one state machine with four states:
- `ST_IDLE`: reads return array data and commands are accepted.
- `ST_PROG`: program timing.
- `ST_ERASE`: erase timing; the array is swept one word per cycle.
- `ST_LOCK`: lock timing.

The transitions are:
- **accept**: `ST_IDLE` goes to the state that matches `cmd_op`.
- **complete**: any timed state returns to `ST_IDLE` in the cycle its counter reaches its limit.
- **reject**: `ST_IDLE` stays in `ST_IDLE` for a program aimed at a locked boot word.

Operation codes on `cmd_op` are:

| Code | Operation |
|------|-----------|
| 0 | program |
| 1 | full-array erase |
| 2 | main-region erase |
| 3 | lock set |

Top module: `flash_op_engine`

## Requirements
- R1: After reset, `busy` is 0, `boot_locked` is 0 and `rd_data` is 0.
- R2: A program (cmd_op 0) stores the old word ANDed with `cmd_data`, so bits can only go from 1 to 0.
- R3: A program holds `busy` for exactly `PROG_CYC` cycles, starting the cycle after the accepting edge, and then returns to normal reads with no further command.
- R4: While `boot_locked` is 1, a program to an address below `BOOT_WORDS` is ignored: `busy` stays 0 and the word keeps its value.
- R5: A full-array erase (cmd_op 1) with the lock clear sets every word, boot region included, to 0xFFFF. It holds `busy` for `max(ERASE_CYC, 2**ADDR_W)` cycles.
- R6: A full-array erase with the lock set leaves boot-region words unchanged and sets main-region words to 0xFFFF.
- R7: A main-region erase (cmd_op 2) sets main-region words to 0xFFFF and never alters the boot region.
- R8: A read accepted while `busy` returns a status word. During a program, bit 15 is the inverse of bit 15 of the word being stored, and bit 7 is the inverse of bit 7 of that word. During an erase or lock, bits 15 and 7 are 0. All bits other than 15, 14, 7 and 6 are 0.
- R9: Bits 14 and 6 of the status word are 0 on the first busy read after an operation starts. They invert on every further busy read.
- R10: A lock set (cmd_op 3) holds `busy` for `LOCK_CYC` cycles and then raises `boot_locked`. Only reset clears `boot_locked`.
- R11: Commands presented while `busy` is 1 are ignored and change no stored word.
- R12: A read accepted while `busy` is 0 returns the stored word at `rd_addr` on `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 2 | Operation code: 0 program, 1 full-array erase, 2 main-region erase, 3 lock set |
| cmd_addr | input | ADDR_W | Word address for a program |
| cmd_data | input | DATA_W | Data word for a program |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data or status word |
| busy | output | 1 | High for the whole duration of an operation |
| boot_locked | output | 1 | Boot-region lock state |

## Verification
A corrupt state register or a wrong cycle counter shows up first on `busy`. `busy` ends early or late against the exact cycle counts, and a stuck state never releases it, which the bench catches within one operation. A wrong erase region or a missed lock check stays invisible until a later read of a boundary word (the last boot word, the first main word, the top word). For that reason the bench reads those words right after each erase. A toggle register that fails to clear or flip shows on the second status read of the same operation.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_CHIP_ERASE = 2'd1,
        OP_MAIN_ERASE = 2'd2,
        OP_LOCK_SET   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_LOCK  = 2'd3
    } state_e;

endpackage

// File: rtl/fe_array.sv
module fe_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Single write port; the contents are not reset, as in a real array.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/fe_timer.sv
module fe_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == limit - 1'b1);

    // The count never passes the limit of the running operation.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));

endmodule

// File: rtl/fe_status.sv
module fe_status #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              start,
    input  logic              poll_hi,
    input  logic              poll_lo,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF = DATA_W / 2;

    logic              tog;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word           = '0;
        status_word[DATA_W-1] = poll_hi;
        status_word[HALF-1]   = poll_lo;
        status_word[DATA_W-2] = tog;
        status_word[HALF-2]   = tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog     <= 1'b0;
            rd_data <= '0;
        end else begin
            if (start) begin
                tog <= 1'b0;
            end else if (rd_en && busy) begin
                tog <= ~tog;
            end
            if (rd_en) begin
                rd_data <= busy ? status_word : arr_word;
            end
        end
    end

    // A busy read carries only the polling and toggle bits, with equal toggle bits in both lanes.
    assert_status_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> ((rd_data[DATA_W-2] == rd_data[HALF-2]) &&
                             (rd_data[DATA_W-3:HALF] == '0) &&
                             (rd_data[HALF-3:0] == '0)));

    // Consecutive busy reads within one operation show inverted toggle bits.
    assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !start) ##1 (rd_en && busy && !start)
        |=> (rd_data[HALF-2] != $past(rd_data[HALF-2])));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_eng_pkg::*;
#(
    parameter int          ADDR_W     = 10,
    parameter int          DATA_W     = 16,
    parameter int unsigned BOOT_WORDS = 128,
    parameter int          PROG_CYC   = 20,
    parameter int          ERASE_CYC  = 1100,
    parameter int          LOCK_CYC   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              boot_locked
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int HALF      = DATA_W / 2;
    localparam int ERASE_LIM = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;
    localparam int MAX_A     = (PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC;
    localparam int MAX_CYC   = (MAX_A > ERASE_LIM) ? MAX_A : ERASE_LIM;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0]  PROG_L  = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0]  ERASE_L = CNT_W'(ERASE_LIM);
    localparam logic [CNT_W-1:0]  LOCK_L  = CNT_W'(LOCK_CYC);
    localparam logic [ADDR_W:0]   BOOT_L  = BOOT_WORDS[ADDR_W:0];

    state_e            state, state_nx;
    logic              accept;
    logic              op_last;
    logic              boot_cmd;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_word;
    logic              erase_all;
    logic [ADDR_W-1:0] sweep_ptr;
    logic              sweep_live;

    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;
    logic [CNT_W-1:0]  limit;
    logic              poll_hi, poll_lo;
    logic [ADDR_W-1:0] raddr_b;
    logic [DATA_W-1:0] rdata_a, rdata_b;

    assign boot_cmd = ({1'b0, cmd_addr} < BOOT_L);
    assign accept   = cmd_valid && (state == ST_IDLE) &&
                      !((op_e'(cmd_op) == OP_PROG) && boot_locked && boot_cmd);
    assign busy     = (state != ST_IDLE);
    assign raddr_b  = (state == ST_IDLE) ? cmd_addr : op_addr;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op_e'(cmd_op))
                        OP_PROG:       state_nx = ST_PROG;
                        OP_CHIP_ERASE: state_nx = ST_ERASE;
                        OP_MAIN_ERASE: state_nx = ST_ERASE;
                        OP_LOCK_SET:   state_nx = ST_LOCK;
                    endcase
                end
            end
            ST_PROG, ST_ERASE, ST_LOCK: begin
                if (op_last) state_nx = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output decode per state
    always_comb begin
        we      = 1'b0;
        waddr   = op_addr;
        wdata   = op_word;
        limit   = PROG_L;
        poll_hi = 1'b0;
        poll_lo = 1'b0;
        unique case (state)
            ST_IDLE: begin
                limit = PROG_L;
            end
            ST_PROG: begin
                we      = op_last;
                limit   = PROG_L;
                poll_hi = ~op_word[DATA_W-1];
                poll_lo = ~op_word[HALF-1];
            end
            ST_ERASE: begin
                limit = ERASE_L;
                waddr = sweep_ptr;
                wdata = '1;
                we    = sweep_live && (erase_all || ({1'b0, sweep_ptr} >= BOOT_L));
            end
            ST_LOCK: begin
                limit = LOCK_L;
            end
        endcase
    end

    // Operation registers and erase sweep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr    <= '0;
            op_word    <= '0;
            erase_all  <= 1'b0;
            sweep_ptr  <= '0;
            sweep_live <= 1'b0;
        end else if (accept) begin
            op_addr    <= cmd_addr;
            op_word    <= rdata_b & cmd_data;
            erase_all  <= (op_e'(cmd_op) == OP_CHIP_ERASE) && !boot_locked;
            sweep_ptr  <= '0;
            sweep_live <= (op_e'(cmd_op) == OP_CHIP_ERASE) ||
                          (op_e'(cmd_op) == OP_MAIN_ERASE);
        end else if ((state == ST_ERASE) && sweep_live) begin
            sweep_ptr <= sweep_ptr + 1'b1;
            if (sweep_ptr == {ADDR_W{1'b1}}) sweep_live <= 1'b0;
        end
    end

    // Lock register: set only by a completed lock operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_locked <= 1'b0;
        end else if ((state == ST_LOCK) && op_last) begin
            boot_locked <= 1'b1;
        end
    end

    fe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .run   (busy),
        .limit (limit),
        .last  (op_last)
    );

    fe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (rd_addr),
        .raddr_b (raddr_b),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b)
    );

    fe_status #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .busy     (busy),
        .start    (accept),
        .poll_hi  (poll_hi),
        .poll_lo  (poll_lo),
        .arr_word (rdata_a),
        .rd_data  (rd_data)
    );

    // A program write never raises a bit of the stored word.
    assert_only_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (state == ST_PROG)) |-> ((wdata & ~rdata_b) == '0));

    // With the lock set, no write lands in the boot region.
    assert_boot_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && boot_locked) |-> ({1'b0, waddr} >= BOOT_L));

    // A running operation keeps its state and target until it completes.
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_last) |=> (busy && $stable(state) && $stable(op_addr)));

    // Completion always returns to normal reads.
    assert_idle_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_last |=> !busy);

    // The lock never clears while out of reset.
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

endmodule

// File: tb/tb_flash_op_engine.sv
module tb_flash_op_engine;
    localparam int AW        = 10;
    localparam int DW        = 16;
    localparam int BOOT      = 128;
    localparam int PROG_CYC  = 20;
    localparam int ERASE_CYC = 1100;
    localparam int LOCK_CYC  = 30;

    // {addr, data, expected word after program}
    localparam logic [41:0] VEC [8] = '{
        {10'd10,   16'h1234, 16'h1234},
        {10'd10,   16'hFF0F, 16'h1204},
        {10'd10,   16'hFFFF, 16'h1204},
        {10'd127,  16'h0F0F, 16'h0F0F},
        {10'd128,  16'hA5A5, 16'hA5A5},
        {10'd128,  16'h5A5A, 16'h0000},
        {10'd1023, 16'h8000, 16'h8000},
        {10'd500,  16'h7FFF, 16'h7FFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          boot_locked;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flash_op_engine #(
        .ADDR_W(AW), .DATA_W(DW), .BOOT_WORDS(BOOT),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LOCK_CYC(LOCK_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .boot_locked(boot_locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int n;

        repeat (3) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 lock after reset", boot_locked, 0);
        chk("R1 rd_data after reset", rd_data, 0);
        rst_n = 1'b1;

        // Full-array erase, lock clear
        issue(2'd1, '0, '0);
        rd(10'd5, d);
        chk("R8 erase status first read", d, 16'h0000);
        rd(10'd5, d);
        chk("R9 erase status second read", d, 16'h4040);
        wait_idle(n);
        chk("R5 erase busy length", n + 4, ERASE_CYC);
        rd(10'd0, d);    chk("R5 word 0 erased", d, 16'hFFFF);
        rd(10'd127, d);  chk("R5 last boot word erased", d, 16'hFFFF);
        rd(10'd128, d);  chk("R5 first main word erased", d, 16'hFFFF);
        rd(10'd1023, d); chk("R5 top word erased", d, 16'hFFFF);

        // Program table
        for (int i = 0; i < 8; i++) begin
            issue(2'd0, VEC[i][41:32], VEC[i][31:16]);
            wait_idle(n);
            chk("R3 program busy length", n, PROG_CYC);
            rd(VEC[i][41:32], d);
            chk("R2 R12 program result", d, VEC[i][15:0]);
        end

        // Status bits while programming 0x0080
        issue(2'd0, 10'd600, 16'h0080);
        rd(10'd600, d); chk("R8 program status first", d, 16'h8000);
        rd(10'd3, d);   chk("R9 program status second", d, 16'hC040);
        rd(10'd600, d); chk("R9 program status third", d, 16'h8000);
        wait_idle(n);
        rd(10'd600, d); chk("R3 R12 true data after program", d, 16'h0080);

        // Commands while busy
        issue(2'd0, 10'd700, 16'h1111);
        issue(2'd0, 10'd701, 16'h0000);
        issue(2'd1, '0, '0);
        chk("R11 still busy", busy, 1);
        wait_idle(n);
        rd(10'd700, d); chk("R11 first program applied", d, 16'h1111);
        rd(10'd701, d); chk("R11 second program ignored", d, 16'hFFFF);
        rd(10'd10, d);  chk("R11 erase while busy ignored", d, 16'h1204);

        // Main-region erase, lock clear
        issue(2'd2, '0, '0);
        wait_idle(n);
        rd(10'd10, d);   chk("R7 boot word kept", d, 16'h1204);
        rd(10'd127, d);  chk("R7 last boot word kept", d, 16'h0F0F);
        rd(10'd128, d);  chk("R7 first main word erased", d, 16'hFFFF);
        rd(10'd1023, d); chk("R7 top word erased", d, 16'hFFFF);

        // Lock set
        issue(2'd3, '0, '0);
        chk("R10 lock not yet set", boot_locked, 0);
        wait_idle(n);
        chk("R10 lock busy length", n, LOCK_CYC);
        chk("R10 lock set", boot_locked, 1);

        // Program into locked boot region
        issue(2'd0, 10'd10, 16'h0000);
        chk("R4 no busy for locked program", busy, 0);
        rd(10'd10, d); chk("R4 locked word unchanged", d, 16'h1204);
        issue(2'd0, 10'd200, 16'h00FF);
        wait_idle(n);
        rd(10'd200, d); chk("R4 main program still works", d, 16'h00FF);

        // Full-array erase with lock set
        issue(2'd1, '0, '0);
        wait_idle(n);
        rd(10'd10, d);  chk("R6 boot word survives", d, 16'h1204);
        rd(10'd127, d); chk("R6 last boot word survives", d, 16'h0F0F);
        rd(10'd128, d); chk("R6 first main word erased", d, 16'hFFFF);
        rd(10'd200, d); chk("R6 main word erased", d, 16'hFFFF);
        chk("R10 lock sticky", boot_locked, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule